// File: doc/BRIEF.md
# Slow-Clock Reset Manager with External Reset Pin

This block runs in the slow clock domain and decides when the processor and its peripherals are held in reset. It watches an active-low, bidirectional reset pin. The pin can be pulled low from outside the chip. The block can also pull the pin low itself for a programmable minimum time. A second reset source is a request raised when the chip comes back from its low-power backup state. Whenever the processor reset is released, a small code records why the last reset happened, so boot firmware can read the cause.

A low on the pin counts only after it has passed a two-stage synchroniser, and only when the user-reset enable input is 1. When either source fires, both internal resets assert together and the processor clock is gated. The block then drives the pin low for 2^(len+1) slow-clock cycles. Release waits until the synchronised pin reads high, whoever holds it low. The processor clock comes back at that point. Both resets then stay asserted for a three-cycle processor startup before they are released together.

Top module: `slow_reset_ctrl`

## Requirements
- R1: The raw pin passes two synchronising flip-flops. A low on the pin set up before edge k asserts the resets at edge k+2, and not before.
- R2: A synchronised low pin with user_en_i = 1 asserts proc_rst_n_o and periph_rst_n_o low in the same cycle, and drops cpu_clk_en_o in that cycle too.
- R3: With user_en_i = 0, a low pin leaves both resets high, leaves pin_drive_o at 0 and leaves rst_kind_o unchanged.
- R4: On entry to any reset, pin_drive_o is 1 for exactly 2^(ext_len_i+1) cycles.
- R5: If the pin is still held low from outside after the drive time, both resets stay asserted until the synchronised pin reads high.
- R6: After the pin rises, cpu_clk_en_o returns 1 at the third edge. Both resets are released three edges after that.
- R7: rst_kind_o changes only on the edge where proc_rst_n_o rises. After a user reset it becomes 3'h4.
- R8: A backup_req_i pulse while running asserts both resets on the next edge and starts the pin drive. At release, rst_kind_o becomes 3'h1.
- R9: When a backup request and an enabled synchronised pin low are seen in the same cycle, the backup source wins and the recorded kind is 3'h1.
- R10: While rst is high, both resets are asserted, pin_drive_o is 0 and rst_kind_o is 3'h0. The resets are released three edges after rst falls, and the kind stays 3'h0.
- R11: periph_rst_n_o always equals proc_rst_n_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| backup_req_i | input | 1 | Reset request on exit from backup state |
| pin_raw_i | input | 1 | Raw level of the active-low reset pin |
| user_en_i | input | 1 | Lets a low pin start a user reset |
| ext_len_i | input | 4 | Pin drive length exponent; the drive lasts 2^(n+1) cycles |
| proc_rst_n_o | output | 1 | Processor reset, active low |
| periph_rst_n_o | output | 1 | Peripheral reset, active low |
| pin_drive_o | output | 1 | Pulls the reset pin low when 1 |
| cpu_clk_en_o | output | 1 | Processor clock enable |
| rst_kind_o | output | 3 | Cause of the last reset: 0 power-up, 1 backup, 4 user |

## Verification
Two sources can fire in the same cycle: the backup-exit request and a user pin low that has just reached the synchroniser output. The bench holds the pin low and counts edges so that backup_req_i is high on exactly the edge at which the synchronised low is first seen. The previous recorded kind is 3'h4, so a wrong priority can be told apart from a correct one. The bench judges the result by the kind code read at release, which must be 3'h1, and by the resets having dropped on that very edge.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
    parameter int unsigned LEN_W  = 4;
    parameter int unsigned CNT_W  = (1 << LEN_W) + 1;
    parameter int unsigned KIND_W = 3;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_HOLD    = 2'd1,
        ST_STARTUP = 2'd2
    } rst_state_e;

    typedef enum logic [KIND_W-1:0] {
        KIND_POWER  = 3'h0,
        KIND_BACKUP = 3'h1,
        KIND_USER   = 3'h4
    } rst_kind_e;

    typedef struct packed {
        logic proc_rst_n;
        logic periph_rst_n;
        logic clk_en;
    } rst_out_t;

    // Number of cycles the pin is pulled low for a given length field.
    function automatic logic [CNT_W-1:0] stretch_cycles(input logic [LEN_W-1:0] len);
        logic [CNT_W-1:0] one;
        one = {{(CNT_W-1){1'b0}}, 1'b1};
        return one << (32'(len) + 32'd1);
    endfunction

    function automatic rst_out_t decode_outputs(input rst_state_e st);
        rst_out_t o;
        o.proc_rst_n   = (st == ST_RUN);
        o.periph_rst_n = (st == ST_RUN);
        o.clk_en       = (st != ST_HOLD);
        return o;
    endfunction
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= RESET_VAL;
                else     chain_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= {STAGES{RESET_VAL}};
                else     chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch
    import rstc_pkg::*;
#(
    parameter int unsigned L_W = LEN_W,
    parameter int unsigned C_W = CNT_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_i,
    input  logic [L_W-1:0] len_i,
    output logic           drive_o,
    output logic           done_o
);
    logic [C_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= C_W'(stretch_cycles(LEN_W'(len_i)));
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign drive_o = (cnt_q != '0);
    assign done_o  = (cnt_q == '0);
endmodule

// File: rtl/rstc_fsm.sv
module rstc_fsm
    import rstc_pkg::*;
#(
    parameter int unsigned STARTUP_CYCLES = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_s_i,
    input  logic       user_en_i,
    input  logic       backup_req_i,
    input  logic       stretch_done_i,
    output rst_state_e state_o,
    output logic       load_o,
    output rst_kind_e  kind_o
);
    localparam int unsigned SU_W = (STARTUP_CYCLES > 1) ? $clog2(STARTUP_CYCLES) : 1;
    localparam logic [SU_W-1:0] SU_LAST = SU_W'(STARTUP_CYCLES - 1);

    rst_state_e      state_q, state_d;
    rst_kind_e       pend_q, pend_d, kind_q;
    logic [SU_W-1:0] su_q, su_d;
    logic            load_d;

    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        su_d    = su_q;
        load_d  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (backup_req_i) begin
                    state_d = ST_HOLD;
                    pend_d  = KIND_BACKUP;
                    load_d  = 1'b1;
                end else if (user_en_i && !pin_s_i) begin
                    state_d = ST_HOLD;
                    pend_d  = KIND_USER;
                    load_d  = 1'b1;
                end
            end
            ST_HOLD: begin
                if (backup_req_i) begin
                    pend_d = KIND_BACKUP;
                    load_d = 1'b1;
                end else if (stretch_done_i && pin_s_i) begin
                    state_d = ST_STARTUP;
                    su_d    = SU_LAST;
                end
            end
            ST_STARTUP: begin
                if (backup_req_i) begin
                    state_d = ST_HOLD;
                    pend_d  = KIND_BACKUP;
                    load_d  = 1'b1;
                end else if (su_q == '0) begin
                    state_d = ST_RUN;
                end else begin
                    su_d = su_q - 1'b1;
                end
            end
            default: state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_STARTUP;
            pend_q  <= KIND_POWER;
            kind_q  <= KIND_POWER;
            su_q    <= SU_LAST;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            su_q    <= su_d;
            if (state_q == ST_STARTUP && state_d == ST_RUN) begin
                kind_q <= pend_q;
            end
        end
    end

    assign state_o = state_q;
    assign load_o  = load_d;
    assign kind_o  = kind_q;
endmodule

// File: rtl/slow_reset_ctrl.sv
module slow_reset_ctrl
    import rstc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES    = 2,
    parameter int unsigned STARTUP_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              backup_req_i,
    input  logic              pin_raw_i,
    input  logic              user_en_i,
    input  logic [LEN_W-1:0]  ext_len_i,
    output logic              proc_rst_n_o,
    output logic              periph_rst_n_o,
    output logic              pin_drive_o,
    output logic              cpu_clk_en_o,
    output logic [KIND_W-1:0] rst_kind_o
);
    logic       pin_sync;
    logic       stretch_load;
    logic       stretch_done;
    rst_state_e state;
    rst_kind_e  kind;
    rst_out_t   outs;

    rstc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pin_raw_i),
        .q_o (pin_sync)
    );

    rstc_stretch u_stretch (
        .clk     (clk),
        .rst     (rst),
        .load_i  (stretch_load),
        .len_i   (ext_len_i),
        .drive_o (pin_drive_o),
        .done_o  (stretch_done)
    );

    rstc_fsm #(.STARTUP_CYCLES(STARTUP_CYCLES)) u_fsm (
        .clk            (clk),
        .rst            (rst),
        .pin_s_i        (pin_sync),
        .user_en_i      (user_en_i),
        .backup_req_i   (backup_req_i),
        .stretch_done_i (stretch_done),
        .state_o        (state),
        .load_o         (stretch_load),
        .kind_o         (kind)
    );

    assign outs           = decode_outputs(state);
    assign proc_rst_n_o   = outs.proc_rst_n;
    assign periph_rst_n_o = outs.periph_rst_n;
    assign cpu_clk_en_o   = outs.clk_en;
    assign rst_kind_o     = kind;
endmodule

// File: rtl/slow_reset_ctrl_chk.sv
module slow_reset_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       backup_req_i,
    input logic       user_en_i,
    input logic       pin_s,
    input logic       proc_rst_n_o,
    input logic       periph_rst_n_o,
    input logic       pin_drive_o,
    input logic       cpu_clk_en_o,
    input logic [2:0] rst_kind_o
);
    // R11
    periph_tracks_proc_chk: assert property (@(posedge clk) disable iff (rst)
        periph_rst_n_o == proc_rst_n_o);

    // R7
    kind_only_at_release_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(rst_kind_o) |-> $rose(proc_rst_n_o));

    // R4
    drive_holds_resets_chk: assert property (@(posedge clk) disable iff (rst)
        pin_drive_o |-> (!proc_rst_n_o && !cpu_clk_en_o));

    // R6
    clock_before_release_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(proc_rst_n_o) |-> $past(cpu_clk_en_o));

    // R2
    user_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (proc_rst_n_o && user_en_i && !pin_s) |=> (!proc_rst_n_o && !cpu_clk_en_o));

    // R3
    user_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        (proc_rst_n_o && !user_en_i && !backup_req_i) |=> proc_rst_n_o);

    // R8
    backup_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (proc_rst_n_o && backup_req_i) |=> (!proc_rst_n_o && pin_drive_o));
endmodule

bind slow_reset_ctrl slow_reset_ctrl_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .backup_req_i   (backup_req_i),
    .user_en_i      (user_en_i),
    .pin_s          (pin_sync),
    .proc_rst_n_o   (proc_rst_n_o),
    .periph_rst_n_o (periph_rst_n_o),
    .pin_drive_o    (pin_drive_o),
    .cpu_clk_en_o   (cpu_clk_en_o),
    .rst_kind_o     (rst_kind_o)
);

// File: tb/slow_reset_ctrl_test.sv
`timescale 1ns/1ps
module slow_reset_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       backup_req = 1'b0;
    logic       ext_lvl = 1'b1;
    logic       user_en = 1'b1;
    logic [3:0] ext_len = 4'd0;
    logic       pin_raw;
    logic       proc_rst_n, periph_rst_n, pin_drive, cpu_clk_en;
    logic [2:0] rst_kind;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    // Open-drain pin: low if driven by the block or held by the outside.
    assign pin_raw = ext_lvl & ~pin_drive;

    slow_reset_ctrl uut (
        .clk            (clk),
        .rst            (rst),
        .backup_req_i   (backup_req),
        .pin_raw_i      (pin_raw),
        .user_en_i      (user_en),
        .ext_len_i      (ext_len),
        .proc_rst_n_o   (proc_rst_n),
        .periph_rst_n_o (periph_rst_n),
        .pin_drive_o    (pin_drive),
        .cpu_clk_en_o   (cpu_clk_en),
        .rst_kind_o     (rst_kind)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wait_release(input string req);
        int n = 0;
        while (!proc_rst_n && n < 500) begin
            step(1);
            n++;
        end
        chk(proc_rst_n == 1'b1, req, proc_rst_n, 1);
    endtask

    task automatic t_power_up();
        @(negedge clk);
        chk(proc_rst_n == 1'b0, "R10", proc_rst_n, 0);
        chk(pin_drive == 1'b0, "R10", pin_drive, 0);
        chk(rst_kind == 3'h0, "R10", rst_kind, 0);
        rst = 1'b0;
        step(2);
        chk(proc_rst_n == 1'b0, "R10", proc_rst_n, 0);
        step(1);
        chk(proc_rst_n == 1'b1, "R10", proc_rst_n, 1);
        chk(rst_kind == 3'h0, "R10", rst_kind, 0);
        chk(periph_rst_n == 1'b1, "R11", periph_rst_n, 1);
    endtask

    task automatic t_user_reset();
        int n;
        ext_len = 4'd2;
        user_en = 1'b1;
        ext_lvl = 1'b0;
        step(2);
        chk(proc_rst_n == 1'b1, "R1", proc_rst_n, 1);
        step(1);
        chk(proc_rst_n == 1'b0, "R2", proc_rst_n, 0);
        chk(periph_rst_n == 1'b0, "R2", periph_rst_n, 0);
        chk(cpu_clk_en == 1'b0, "R2", cpu_clk_en, 0);
        n = 0;
        while (pin_drive && n < 100) begin
            n++;
            step(1);
        end
        chk(n == 8, "R4", n, 8);
        step(6);
        chk(proc_rst_n == 1'b0, "R5", proc_rst_n, 0);
        chk(cpu_clk_en == 1'b0, "R5", cpu_clk_en, 0);
        ext_lvl = 1'b1;
        step(2);
        chk(cpu_clk_en == 1'b0, "R6", cpu_clk_en, 0);
        step(1);
        chk(cpu_clk_en == 1'b1, "R6", cpu_clk_en, 1);
        chk(proc_rst_n == 1'b0, "R6", proc_rst_n, 0);
        chk(rst_kind == 3'h0, "R7", rst_kind, 0);
        step(2);
        chk(proc_rst_n == 1'b0, "R6", proc_rst_n, 0);
        step(1);
        chk(proc_rst_n == 1'b1, "R6", proc_rst_n, 1);
        chk(periph_rst_n == 1'b1, "R11", periph_rst_n, 1);
        chk(rst_kind == 3'h4, "R7", rst_kind, 4);
    endtask

    task automatic t_user_disabled();
        user_en = 1'b0;
        ext_lvl = 1'b0;
        for (int i = 0; i < 8; i++) begin
            step(1);
            if (!proc_rst_n || pin_drive) begin
                chk(1'b0, "R3", {pin_drive, proc_rst_n}, 1);
            end
        end
        chk(proc_rst_n == 1'b1, "R3", proc_rst_n, 1);
        chk(pin_drive == 1'b0, "R3", pin_drive, 0);
        chk(rst_kind == 3'h4, "R3", rst_kind, 4);
        ext_lvl = 1'b1;
        step(3);
        user_en = 1'b1;
    endtask

    task automatic t_backup();
        int n;
        ext_len = 4'd0;
        backup_req = 1'b1;
        step(1);
        backup_req = 1'b0;
        chk(proc_rst_n == 1'b0, "R8", proc_rst_n, 0);
        n = 0;
        while (pin_drive && n < 100) begin
            n++;
            step(1);
        end
        chk(n == 2, "R4", n, 2);
        wait_release("R8");
        chk(rst_kind == 3'h1, "R8", rst_kind, 1);
    endtask

    task automatic t_collision();
        // Give the kind a user value first so the winner can be told apart.
        ext_lvl = 1'b0;
        step(3);
        ext_lvl = 1'b1;
        wait_release("R7");
        chk(rst_kind == 3'h4, "R7", rst_kind, 4);
        ext_lvl = 1'b0;
        step(2);
        backup_req = 1'b1;
        chk(proc_rst_n == 1'b1, "R9", proc_rst_n, 1);
        step(1);
        backup_req = 1'b0;
        chk(proc_rst_n == 1'b0, "R9", proc_rst_n, 0);
        step(4);
        ext_lvl = 1'b1;
        wait_release("R9");
        chk(rst_kind == 3'h1, "R9", rst_kind, 1);
    endtask

    initial begin
        t_power_up();
        t_user_reset();
        t_user_disabled();
        t_backup();
        t_collision();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule